// File: doc/BRIEF.md
# Disk Controller DMA Request Handshake

This block drives the data-transfer request line of a floppy-style disk controller towards a host DMA channel. While a data-transfer command is in its execution phase and DMA has been allowed, it raises a request. It watches the host's active-low acknowledge. For each acknowledged cycle it emits a one-cycle access strobe towards the data FIFO. No address is involved in that access. A per-command byte counter and a terminal-count input decide when the transfer is over. At that point the request is withdrawn and a done pulse is given.

Two request policies are available through a configuration input. In single policy the request is released after every acknowledge and raised again once the acknowledge goes away. In burst policy the request is held through all acknowledges until the last byte. A verify pseudo-read replaces the FIFO strobe when the FIFO is disabled (byte mode), a read command runs and the DMA channel works in verify mode. Two strap pins choose the interface flavour. The flavour sets the terminal-count polarity, whether the DMA-enable bit gates the request, and whether the request and interrupt pads are always driven. The configuration register that feeds `cfg_nburst_i` is expected to come out of reset at 1, which selects single policy.

Top module: `dkc_dma_req`

## Requirements
- R1: After reset, drq_o, fifo_strb_o, pseudo_rd_o and xfer_done_o are all 0.
- R2: drq_o rises one cycle after a clock edge that sees exec_i=1, spec_dma_i=1, DMA permitted by the mode (R9 to R11) and the current transfer not yet finished; otherwise drq_o stays 0.
- R3: With cfg_nburst_i=1 (single policy), drq_o is 0 in the cycle after the edge that first samples dack_ni=0, and it stays 0 while the acknowledge is held. It is 1 again in the cycle after dack_ni=1 is sampled, as long as transfers remain.
- R4: With cfg_nburst_i=0 (burst policy), drq_o stays 1 through every acknowledge, whatever dack_ni does, until the final transfer.
- R5: start_i loads xfer_len_i (which must be 1 or more). On the acknowledge that completes that many transfers, drq_o goes to 0 and xfer_done_o pulses for one cycle in the next cycle. The transfer then stays finished until the next start_i.
- R6: A terminal count that is active, after polarity normalisation, when an acknowledge begins ends the transfer in the same way as R5, under both policies.
- R7: Each falling edge of dack_ni during an active transfer yields exactly one fifo_strb_o pulse, one cycle long, in the following cycle. An acknowledge while no transfer is active yields no strobe.
- R8: When verify_i=1, fifo_en_i=0 and rd_cmd_i=1 at the acknowledge edge, pseudo_rd_o pulses instead of fifo_strb_o. In all other combinations fifo_strb_o pulses.
- R9: strap_a_i=0 with strap_b_i=1 selects mode P. In mode P dor_dma_en_i is ignored, drq_oe_o and int_oe_o are 1, and terminal count is active when tc_i=0.
- R10: strap_a_i=0 with strap_b_i=0 selects mode M. In mode M a request needs dor_dma_en_i=1, drq_oe_o and int_oe_o equal dor_dma_en_i, and terminal count is active when tc_i=1.
- R11: strap_a_i=1 selects mode A. In mode A a request needs dor_dma_en_i=1, drq_oe_o and int_oe_o are 1, and terminal count is active when tc_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_a_i | input | 1 | Interface strap A |
| strap_b_i | input | 1 | Interface strap B |
| cfg_nburst_i | input | 1 | 1 selects single policy, 0 selects burst |
| dor_dma_en_i | input | 1 | DMA-enable bit from the output register |
| spec_dma_i | input | 1 | DMA selected by the specify command |
| exec_i | input | 1 | Data-transfer command is in its execution phase |
| start_i | input | 1 | Loads the byte count and opens a new transfer |
| xfer_len_i | input | CNT_W | Number of bytes in the transfer |
| fifo_en_i | input | 1 | FIFO enabled (0 means byte mode) |
| rd_cmd_i | input | 1 | Active command is a read |
| verify_i | input | 1 | DMA channel runs in verify mode |
| dack_ni | input | 1 | Host DMA acknowledge, active low |
| tc_i | input | 1 | Raw terminal count, polarity set by the mode |
| drq_o | output | 1 | DMA request |
| drq_oe_o | output | 1 | Pad enable for the request |
| int_oe_o | output | 1 | Pad enable for the interrupt |
| fifo_strb_o | output | 1 | FIFO access strobe, one per acknowledge |
| pseudo_rd_o | output | 1 | Verify pseudo-read strobe |
| xfer_done_o | output | 1 | One-cycle pulse when the transfer ends |

## Verification
The registered results (drq_o, fifo_strb_o, pseudo_rd_o and xfer_done_o) each settle exactly one clock after the edge that samples their cause: an acknowledge edge, an acknowledge release or a start. The pad enables follow the straps and dor_dma_en_i with no delay. The bench changes every input on the falling clock edge and reads the results on the next falling edge, one rising edge later. Because of this, every expected value is tied to a single sampling edge. A check made two half-periods after an acknowledge edge therefore sees the effect of that edge and nothing later.

// File: rtl/dkc_dma_pkg.sv
package dkc_dma_pkg;
  typedef enum logic [1:0] {
    MODE_M = 2'd0,
    MODE_P = 2'd1,
    MODE_A = 2'd2
  } dkc_mode_e;
endpackage

// File: rtl/dkc_mode_dec.sv
module dkc_mode_dec
  import dkc_dma_pkg::*;
(
  input  logic      strap_a_i,
  input  logic      strap_b_i,
  input  logic      dor_dma_en_i,
  input  logic      tc_i,
  output dkc_mode_e mode_o,
  output logic      dma_ok_o,
  output logic      tc_act_o,
  output logic      pad_oe_o
);
  always_comb begin
    if (strap_a_i)      mode_o = MODE_A;
    else if (strap_b_i) mode_o = MODE_P;
    else                mode_o = MODE_M;
  end

  always_comb begin
    unique case (mode_o)
      MODE_P: begin
        dma_ok_o = 1'b1;
        tc_act_o = ~tc_i;
        pad_oe_o = 1'b1;
      end
      MODE_A: begin
        dma_ok_o = dor_dma_en_i;
        tc_act_o = tc_i;
        pad_oe_o = 1'b1;
      end
      default: begin
        dma_ok_o = dor_dma_en_i;
        tc_act_o = tc_i;
        pad_oe_o = dor_dma_en_i;
      end
    endcase
  end
endmodule

// File: rtl/dkc_xfer_cnt.sv
module dkc_xfer_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= len_i;
    else if (dec_i)  rem_q <= rem_q - ONE;
  end

  assign last_o = (rem_q == ONE);
endmodule

// File: rtl/dkc_req_seq.sv
module dkc_req_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic single_i,
  input  logic run_i,
  input  logic start_i,
  input  logic dack_act_i,
  input  logic tc_act_i,
  input  logic last_i,
  input  logic verify_i,
  input  logic fifo_en_i,
  input  logic rd_cmd_i,
  output logic cnt_dec_o,
  output logic drq_o,
  output logic fifo_strb_o,
  output logic pseudo_rd_o,
  output logic done_o
);
  logic dack_q, drq_q, done_q, strb_q, prd_q, dpls_q;
  logic ack_edge, active, end_now, pseudo_ok;

  assign ack_edge  = dack_act_i & ~dack_q;
  assign active    = run_i & ~done_q;
  assign end_now   = active & ack_edge & (last_i | tc_act_i);
  // pseudo read only in byte mode on a read
  assign pseudo_ok = verify_i & ~fifo_en_i & rd_cmd_i;
  assign cnt_dec_o = active & ack_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dack_q <= 1'b0;
      drq_q  <= 1'b0;
      done_q <= 1'b0;
      strb_q <= 1'b0;
      prd_q  <= 1'b0;
      dpls_q <= 1'b0;
    end else begin
      dack_q <= dack_act_i;
      drq_q  <= active & ~end_now & (~single_i | ~dack_act_i);
      done_q <= start_i ? 1'b0 : (done_q | end_now);
      strb_q <= active & ack_edge & ~pseudo_ok;
      prd_q  <= active & ack_edge & pseudo_ok;
      dpls_q <= end_now;
    end
  end

  assign drq_o       = drq_q;
  assign fifo_strb_o = strb_q;
  assign pseudo_rd_o = prd_q;
  assign done_o      = dpls_q;
endmodule

// File: rtl/dkc_dma_req.sv
module dkc_dma_req
  import dkc_dma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_a_i,
  input  logic             strap_b_i,
  input  logic             cfg_nburst_i,
  input  logic             dor_dma_en_i,
  input  logic             spec_dma_i,
  input  logic             exec_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] xfer_len_i,
  input  logic             fifo_en_i,
  input  logic             rd_cmd_i,
  input  logic             verify_i,
  input  logic             dack_ni,
  input  logic             tc_i,
  output logic             drq_o,
  output logic             drq_oe_o,
  output logic             int_oe_o,
  output logic             fifo_strb_o,
  output logic             pseudo_rd_o,
  output logic             xfer_done_o
);
  dkc_mode_e mode;
  logic      dma_ok, tc_act, pad_oe, last, cnt_dec, run;

  dkc_mode_dec u_mode (
    .strap_a_i    (strap_a_i),
    .strap_b_i    (strap_b_i),
    .dor_dma_en_i (dor_dma_en_i),
    .tc_i         (tc_i),
    .mode_o       (mode),
    .dma_ok_o     (dma_ok),
    .tc_act_o     (tc_act),
    .pad_oe_o     (pad_oe)
  );

  assign run = exec_i & spec_dma_i & dma_ok;

  dkc_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .len_i  (xfer_len_i),
    .dec_i  (cnt_dec),
    .last_o (last)
  );

  dkc_req_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .single_i    (cfg_nburst_i),
    .run_i       (run),
    .start_i     (start_i),
    .dack_act_i  (~dack_ni),
    .tc_act_i    (tc_act),
    .last_i      (last),
    .verify_i    (verify_i),
    .fifo_en_i   (fifo_en_i),
    .rd_cmd_i    (rd_cmd_i),
    .cnt_dec_o   (cnt_dec),
    .drq_o       (drq_o),
    .fifo_strb_o (fifo_strb_o),
    .pseudo_rd_o (pseudo_rd_o),
    .done_o      (xfer_done_o)
  );

  assign drq_oe_o = pad_oe;
  assign int_oe_o = pad_oe;
endmodule

// File: rtl/dkc_dma_req_chk.sv
module dkc_dma_req_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic strap_a_i,
  input logic strap_b_i,
  input logic cfg_nburst_i,
  input logic exec_i,
  input logic fifo_en_i,
  input logic rd_cmd_i,
  input logic verify_i,
  input logic dack_ni,
  input logic drq_o,
  input logic drq_oe_o,
  input logic int_oe_o,
  input logic fifo_strb_o,
  input logic pseudo_rd_o,
  input logic xfer_done_o
);
  a_r2_no_req_outside_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !drq_o);

  a_r3_single_drops_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_nburst_i && !dack_ni) |=> !drq_o);

  a_r5_done_clears_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> !drq_o);

  a_r7_strobe_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_strb_o |-> $past(!dack_ni));

  a_r8_pseudo_only_byte_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pseudo_rd_o |-> $past(verify_i && !fifo_en_i && rd_cmd_i && !dack_ni));

  a_r8_one_strobe_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_strb_o, pseudo_rd_o}));

  a_r9_mode_p_pads_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strap_a_i && strap_b_i) |-> (drq_oe_o && int_oe_o));
endmodule

bind dkc_dma_req dkc_dma_req_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_a_i    (strap_a_i),
  .strap_b_i    (strap_b_i),
  .cfg_nburst_i (cfg_nburst_i),
  .exec_i       (exec_i),
  .fifo_en_i    (fifo_en_i),
  .rd_cmd_i     (rd_cmd_i),
  .verify_i     (verify_i),
  .dack_ni      (dack_ni),
  .drq_o        (drq_o),
  .drq_oe_o     (drq_oe_o),
  .int_oe_o     (int_oe_o),
  .fifo_strb_o  (fifo_strb_o),
  .pseudo_rd_o  (pseudo_rd_o),
  .xfer_done_o  (xfer_done_o)
);

// File: tb/dkc_dma_req_tb_top.sv
module dkc_dma_req_tb_top;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic strap_a_i = 1'b0, strap_b_i = 1'b0, cfg_nburst_i = 1'b1;
  logic dor_dma_en_i = 1'b0, spec_dma_i = 1'b0, exec_i = 1'b0, start_i = 1'b0;
  logic [CNT_W-1:0] xfer_len_i = '0;
  logic fifo_en_i = 1'b1, rd_cmd_i = 1'b0, verify_i = 1'b0;
  logic dack_ni = 1'b1, tc_i = 1'b0;
  logic drq_o, drq_oe_o, int_oe_o, fifo_strb_o, pseudo_rd_o, xfer_done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5ns clk_i = ~clk_i;

  dkc_dma_req #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_a_i(strap_a_i), .strap_b_i(strap_b_i),
    .cfg_nburst_i(cfg_nburst_i), .dor_dma_en_i(dor_dma_en_i), .spec_dma_i(spec_dma_i),
    .exec_i(exec_i), .start_i(start_i), .xfer_len_i(xfer_len_i), .fifo_en_i(fifo_en_i),
    .rd_cmd_i(rd_cmd_i), .verify_i(verify_i), .dack_ni(dack_ni), .tc_i(tc_i),
    .drq_o(drq_o), .drq_oe_o(drq_oe_o), .int_oe_o(int_oe_o), .fifo_strb_o(fifo_strb_o),
    .pseudo_rd_o(pseudo_rd_o), .xfer_done_o(xfer_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // m: 0=M, 1=P, 2=A
  task automatic set_mode(input int m);
    strap_a_i = (m == 2);
    strap_b_i = (m == 1);
  endtask

  function automatic bit tc_level(input int m, input bit act);
    return (m == 1) ? ~act : act;
  endfunction

  task automatic open_xfer(input int len);
    @(negedge clk_i);
    exec_i = 1'b1; spec_dma_i = 1'b1; start_i = 1'b1; xfer_len_i = CNT_W'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic run_xfer(input int m, input bit single, input int len, input int tc_at, input bit pv);
    int n_end;
    bit want_pv;
    set_mode(m);
    cfg_nburst_i = single;
    dor_dma_en_i = 1'b1;
    tc_i = tc_level(m, 1'b0);
    verify_i = pv; fifo_en_i = ~pv; rd_cmd_i = pv;
    want_pv = pv;
    n_end = (tc_at != 0 && tc_at < len) ? tc_at : len;
    open_xfer(len);
    chk(drq_o == 1'b1, "R2", drq_o, 1);
    chk(drq_oe_o == 1'b1 && int_oe_o == 1'b1, (m == 1) ? "R9" : (m == 2) ? "R11" : "R10", drq_oe_o, 1);
    for (int b = 1; b <= n_end; b++) begin
      dack_ni = 1'b0;
      tc_i = tc_level(m, b == tc_at);
      @(negedge clk_i);
      chk(fifo_strb_o == !want_pv, "R7", fifo_strb_o, !want_pv);
      chk(pseudo_rd_o == want_pv, "R8", pseudo_rd_o, want_pv);
      if (b == tc_at && tc_at < len)
        chk(xfer_done_o == 1'b1 && drq_o == 1'b0, (m == 1) ? "R6 R9" : "R6", xfer_done_o, 1);
      else if (b == n_end)
        chk(xfer_done_o == 1'b1 && drq_o == 1'b0, "R5", xfer_done_o, 1);
      else if (single)
        chk(drq_o == 1'b0 && xfer_done_o == 1'b0, "R3", drq_o, 0);
      else
        chk(drq_o == 1'b1 && xfer_done_o == 1'b0, "R4", drq_o, 1);
      dack_ni = 1'b1;
      tc_i = tc_level(m, 1'b0);
      @(negedge clk_i);
      chk(fifo_strb_o == 1'b0 && pseudo_rd_o == 1'b0, "R7", fifo_strb_o, 0);
      if (b == n_end)
        chk(drq_o == 1'b0, "R5", drq_o, 0);
      else
        chk(drq_o == 1'b1, single ? "R3" : "R4", drq_o, 1);
    end
    // finished transfer: a further acknowledge must do nothing
    dack_ni = 1'b0;
    @(negedge clk_i);
    dack_ni = 1'b1;
    @(negedge clk_i);
    chk(fifo_strb_o == 1'b0 && drq_o == 1'b0, "R5", drq_o, 0);
  endtask

  // straps and dma-enable gating with no transfer in flight
  task automatic gate_case(input int m, input bit dor);
    set_mode(m);
    dor_dma_en_i = dor;
    cfg_nburst_i = 1'b1;
    tc_i = tc_level(m, 1'b0);
    verify_i = 1'b0; fifo_en_i = 1'b1;
    open_xfer(4);
    if (m == 0) begin
      chk(drq_o == dor, "R10", drq_o, dor);
      chk(drq_oe_o == dor && int_oe_o == dor, "R10", drq_oe_o, dor);
    end else if (m == 1) begin
      chk(drq_o == 1'b1, "R9", drq_o, 1);
      chk(drq_oe_o == 1'b1 && int_oe_o == 1'b1, "R9", drq_oe_o, 1);
    end else begin
      chk(drq_o == dor, "R11", drq_o, dor);
      chk(drq_oe_o == 1'b1 && int_oe_o == 1'b1, "R11", drq_oe_o, 1);
    end
    dack_ni = 1'b0;
    @(negedge clk_i);
    chk(fifo_strb_o == (m == 1 || dor), "R7", fifo_strb_o, (m == 1 || dor));
    dack_ni = 1'b1;
    exec_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(drq_o == 1'b0 && fifo_strb_o == 1'b0 && pseudo_rd_o == 1'b0 && xfer_done_o == 1'b0,
        "R1", drq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(drq_o == 1'b0 && xfer_done_o == 1'b0, "R1", drq_o, 0);

    // spec flag off and exec off keep the request low
    set_mode(1);
    dor_dma_en_i = 1'b1;
    open_xfer(3);
    spec_dma_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk(drq_o == 1'b0, "R2", drq_o, 0);
    spec_dma_i = 1'b1; exec_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk(drq_o == 1'b0, "R2", drq_o, 0);

    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 2; d++)
        gate_case(m, d[0]);

    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int len = 1; len <= 4; len++)
          for (int t = 0; t <= len; t++)
            run_xfer(m, s[0], len, t, (len == 2) && (t == 0));

    // verify requested but FIFO enabled: ordinary strobe
    set_mode(2); cfg_nburst_i = 1'b0; dor_dma_en_i = 1'b1; tc_i = 1'b0;
    verify_i = 1'b1; rd_cmd_i = 1'b1; fifo_en_i = 1'b1;
    open_xfer(2);
    dack_ni = 1'b0;
    @(negedge clk_i);
    chk(fifo_strb_o == 1'b1 && pseudo_rd_o == 1'b0, "R8", pseudo_rd_o, 0);
    dack_ni = 1'b1;
    // byte mode but a write command: ordinary strobe
    fifo_en_i = 1'b0; rd_cmd_i = 1'b0;
    @(negedge clk_i);
    dack_ni = 1'b0;
    @(negedge clk_i);
    chk(fifo_strb_o == 1'b1 && pseudo_rd_o == 1'b0, "R8", pseudo_rd_o, 0);
    dack_ni = 1'b1;
    @(negedge clk_i);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule